// File: doc/BRIEF.md
# Receive Address Screen for Bit-Oriented Frames

This block sits behind a receive deframer and decides, frame by frame, whether an incoming frame is kept. Its input is a byte stream with start and end markers on the first and last byte of each frame. A 3-bit mode input picks the kind of address recognition. Two low address registers and two high address registers supply the values the address bytes are compared against. The mode is captured with the start byte and stays fixed for that frame.

The first address byte, or the first two, are parked inside the block until the verdict is known. On a match, the parked bytes and the rest of the frame leave on the output stream in order. On a mismatch, nothing of the frame leaves the block. A one-cycle accept or reject pulse reports each verdict. Two match codes tell which register, or which broadcast value, produced the hit.

Top module: `rxa_addr_screen`

## Requirements
- R1: Mode 000 or 010 (single-byte low recognition): a frame is accepted when its first byte equals `rx_low_a` or `rx_low_b`.
- R2: Mode 001 or 011 (two-byte recognition): a frame is accepted when its first byte equals `rx_high_a`, `rx_high_b`, 0xFE or 0xFC and its second byte equals `rx_low_a` or `rx_low_b`.
- R3: Mode 101 (high-only recognition): a frame is accepted when its first byte equals `rx_high_a` or `rx_high_b`. The values 0xFE and 0xFC do not count as a hit in this mode.
- R4: Modes 100, 110 and 111 perform no recognition, and every frame is accepted.
- R5: `frame_accept` or `frame_reject` is high for exactly one cycle per decided frame, in the cycle after the clock edge that samples the deciding byte. The two are never high together, and both are low after reset.
- R6: When `frame_accept` pulses, the match codes are updated. `match_high` is 1 for `rx_high_a`, 2 for `rx_high_b` and 3 for a broadcast value. `match_low` is 1 for `rx_low_a` and 2 for `rx_low_b`. The lower code wins when two registers hold the same value, and a code that the mode does not use is 0. A reject clears both codes. Between verdicts, both codes hold their value.
- R7: The bytes of an accepted frame appear on `out_data`, with `out_valid`, in the order they arrived. Start and end markers stay attached to their bytes.
- R8: No byte of a rejected frame ever appears with `out_valid` high.
- R9: A frame whose end marker arrives before the number of address bytes its mode needs is rejected.
- R10: The block drops valid bytes that arrive outside a frame. A start marker that arrives while the previous frame is still undecided discards that frame's parked bytes and gives it no verdict. A change of `mode` in the middle of a frame has no effect on that frame.
- R11: The internal hold queue never overflows, whatever the gaps between input bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, releases synchronously |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| mode | input | 3 | Recognition mode, captured with the start byte |
| rx_low_a | input | 8 | Low address register 1 |
| rx_low_b | input | 8 | Low address register 2 |
| rx_high_a | input | 8 | High address register 1 |
| rx_high_b | input | 8 | High address register 2 |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | Output byte starts a frame |
| out_eof | output | 1 | Output byte ends a frame |
| frame_accept | output | 1 | One-cycle accept pulse |
| frame_reject | output | 1 | One-cycle reject pulse |
| match_high | output | 2 | Which high-side comparison hit |
| match_low | output | 2 | Which low-side comparison hit |

## Verification
The verdict pulse and the new match codes are due one cycle after the edge that samples the deciding byte. That byte is the first byte of the frame, or the second byte in two-byte mode. An input byte leaves the block no earlier than the edge after the one that stores it. The parked address bytes leave from the edge after the verdict onwards, one per cycle. The bench holds a behavioural queue model that it steps on every rising edge from the same sampled inputs. It compares every output against that model on the following falling edge, so each expected value is checked in exactly the cycle it is due.

// File: rtl/rxa_pkg.sv
package rxa_pkg;

  // verdict state of one parked byte
  typedef enum logic [1:0] {
    ST_DROP = 2'd0,
    ST_KEEP = 2'd1,
    ST_PEND = 2'd2
  } slot_st_e;

  // recognition flavour derived from the 3-bit mode code
  typedef enum logic [1:0] {
    MK_PLAIN  = 2'd0,
    MK_LOW8   = 2'd1,
    MK_FULL16 = 2'd2,
    MK_HIGH8  = 2'd3
  } mode_kind_e;

  function automatic mode_kind_e decode_mode(input logic [2:0] m);
    case (m)
      3'b000, 3'b010: return MK_LOW8;
      3'b001, 3'b011: return MK_FULL16;
      3'b101:         return MK_HIGH8;
      default:        return MK_PLAIN;
    endcase
  endfunction

endpackage

// File: rtl/rxa_addr_compare.sv
module rxa_addr_compare
  import rxa_pkg::*;
#(
  parameter int          DW    = 8,
  parameter logic [DW-1:0] BC0 = 8'hFE,
  parameter logic [DW-1:0] BC1 = 8'hFC
) (
  input  mode_kind_e    kind,
  input  logic [DW-1:0] first_b,
  input  logic [DW-1:0] second_b,
  input  logic [DW-1:0] low_a,
  input  logic [DW-1:0] low_b,
  input  logic [DW-1:0] high_a,
  input  logic [DW-1:0] high_b,
  output logic          pass,
  output logic [1:0]    hi_code,
  output logic [1:0]    lo_code
);

  logic [1:0]    hi_raw;
  logic [1:0]    lo_raw;
  logic [DW-1:0] lo_src;

  always_comb begin
    if (first_b == high_a)                       hi_raw = 2'd1;
    else if (first_b == high_b)                  hi_raw = 2'd2;
    else if (first_b == BC0 || first_b == BC1)   hi_raw = 2'd3;
    else                                         hi_raw = 2'd0;

    lo_src = (kind == MK_LOW8) ? first_b : second_b;
    if (lo_src == low_a)      lo_raw = 2'd1;
    else if (lo_src == low_b) lo_raw = 2'd2;
    else                      lo_raw = 2'd0;

    case (kind)
      MK_LOW8: begin
        pass    = (lo_raw != 2'd0);
        hi_code = 2'd0;
        lo_code = lo_raw;
      end
      MK_FULL16: begin
        pass    = (hi_raw != 2'd0) && (lo_raw != 2'd0);
        hi_code = hi_raw;
        lo_code = lo_raw;
      end
      MK_HIGH8: begin
        hi_code = (hi_raw == 2'd3) ? 2'd0 : hi_raw;
        pass    = (hi_code != 2'd0);
        lo_code = 2'd0;
      end
      default: begin
        pass    = 1'b1;
        hi_code = 2'd0;
        lo_code = 2'd0;
      end
    endcase
  end

endmodule

// File: rtl/rxa_frame_track.sv
module rxa_frame_track
  import rxa_pkg::*;
#(
  parameter int            DW  = 8,
  parameter logic [DW-1:0] BC0 = 8'hFE,
  parameter logic [DW-1:0] BC1 = 8'hFC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic [2:0]    mode,
  input  logic [DW-1:0] low_a,
  input  logic [DW-1:0] low_b,
  input  logic [DW-1:0] high_a,
  input  logic [DW-1:0] high_b,
  output logic          push,
  output slot_st_e      push_st,
  output logic          res_en,
  output logic          res_keep,
  output logic          accept,
  output logic          reject,
  output logic [1:0]    match_hi,
  output logic [1:0]    match_lo
);

  logic          active_q, active_d;
  logic          decided_q, decided_d;
  logic          keep_q, keep_d;
  logic          have_q, have_d;
  logic [DW-1:0] first_q, first_d;
  mode_kind_e    kind_q, kind_d, kind_cur;
  logic          accept_d, reject_d;
  logic [1:0]    mhi_d, mlo_d;

  logic          start, live, first_seen, undecided, need2;
  logic          at_decide, short_end, abandon;
  logic          pass;
  logic [1:0]    hi_code, lo_code;
  logic [DW-1:0] cmp_first;

  assign start      = in_valid & in_sof;
  assign live       = in_valid & (in_sof | active_q);
  assign kind_cur   = start ? decode_mode(mode) : kind_q;
  assign first_seen = ~start & have_q;
  assign undecided  = start | ~decided_q;
  assign need2      = (kind_cur == MK_FULL16);
  assign at_decide  = live & undecided & (~need2 | first_seen);
  assign short_end  = live & undecided & ~at_decide & in_eof;
  assign abandon    = start & active_q & ~decided_q;
  assign cmp_first  = first_seen ? first_q : in_data;

  rxa_addr_compare #(.DW(DW), .BC0(BC0), .BC1(BC1)) u_cmp (
    .kind     (kind_cur),
    .first_b  (cmp_first),
    .second_b (in_data),
    .low_a    (low_a),
    .low_b    (low_b),
    .high_a   (high_a),
    .high_b   (high_b),
    .pass     (pass),
    .hi_code  (hi_code),
    .lo_code  (lo_code)
  );

  // queue-side controls
  always_comb begin
    if (!live || short_end)  push = 1'b0;
    else if (!undecided)     push = keep_q;
    else if (at_decide)      push = pass;
    else                     push = 1'b1;
    push_st  = (undecided & ~at_decide) ? ST_PEND : ST_KEEP;
    // parked slots at a start byte always belong to the older frame
    res_en   = abandon | (~start & (at_decide | short_end));
    res_keep = ~start & at_decide & pass;
  end

  // next state
  always_comb begin
    active_d  = live ? ~in_eof : active_q;
    decided_d = live ? (at_decide | short_end | (~start & decided_q)) : decided_q;
    keep_d    = at_decide ? pass : (short_end ? 1'b0 : keep_q);
    have_d    = live ? 1'b1 : have_q;
    first_d   = (live & ~first_seen) ? in_data : first_q;
    kind_d    = start ? kind_cur : kind_q;
    accept_d  = at_decide & pass;
    reject_d  = (at_decide & ~pass) | short_end;
    mhi_d     = match_hi;
    mlo_d     = match_lo;
    if (at_decide) begin
      mhi_d = pass ? hi_code : 2'd0;
      mlo_d = pass ? lo_code : 2'd0;
    end else if (short_end) begin
      mhi_d = 2'd0;
      mlo_d = 2'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      decided_q <= 1'b0;
      keep_q    <= 1'b0;
      have_q    <= 1'b0;
      first_q   <= '0;
      kind_q    <= MK_PLAIN;
      accept    <= 1'b0;
      reject    <= 1'b0;
      match_hi  <= 2'd0;
      match_lo  <= 2'd0;
    end else begin
      active_q  <= active_d;
      decided_q <= decided_d;
      keep_q    <= keep_d;
      have_q    <= have_d;
      first_q   <= first_d;
      kind_q    <= kind_d;
      accept    <= accept_d;
      reject    <= reject_d;
      match_hi  <= mhi_d;
      match_lo  <= mlo_d;
    end
  end

endmodule

// File: rtl/rxa_hold_fifo.sv
module rxa_hold_fifo
  import rxa_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          push_sof,
  input  logic          push_eof,
  input  slot_st_e      push_st,
  input  logic          res_en,
  input  logic          res_keep,
  output logic          pop,
  output logic          full,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_sof,
  output logic          out_eof
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [PW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_en;
  logic          emit;

  logic [DW-1:0] dat_q [DEPTH];
  logic          sof_q [DEPTH];
  logic          eof_q [DEPTH];
  slot_st_e      st_q  [DEPTH];
  slot_st_e      st_d  [DEPTH];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt_q == CW'(DEPTH));
  assign pop   = (cnt_q != '0) && (st_q[rd_q] != ST_PEND);
  assign emit  = pop && (st_q[rd_q] == ST_KEEP);
  assign wr_en = push && (!full || pop);

  always_comb begin
    rd_d  = pop   ? bump(rd_q) : rd_q;
    wr_d  = wr_en ? bump(wr_q) : wr_q;
    cnt_d = cnt_q + CW'(wr_en) - CW'(pop);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_comb begin
      st_d[i] = st_q[i];
      if (res_en && st_q[i] == ST_PEND) st_d[i] = res_keep ? ST_KEEP : ST_DROP;
      if (wr_en && wr_q == PW'(i))      st_d[i] = push_st;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[i] <= ST_DROP;
      else        st_q[i] <= st_d[i];
    end

    always_ff @(posedge clk) begin
      if (wr_en && wr_q == PW'(i)) begin
        dat_q[i] <= push_data;
        sof_q[i] <= push_sof;
        eof_q[i] <= push_eof;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q      <= '0;
      wr_q      <= '0;
      cnt_q     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
    end else begin
      rd_q      <= rd_d;
      wr_q      <= wr_d;
      cnt_q     <= cnt_d;
      out_valid <= emit;
      if (emit) begin
        out_data <= dat_q[rd_q];
        out_sof  <= sof_q[rd_q];
        out_eof  <= eof_q[rd_q];
      end
    end
  end

endmodule

// File: rtl/rxa_addr_screen.sv
module rxa_addr_screen
  import rxa_pkg::*;
#(
  parameter int            DW    = 8,
  parameter int            DEPTH = 4,
  parameter logic [DW-1:0] BC0   = 8'hFE,
  parameter logic [DW-1:0] BC1   = 8'hFC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic [2:0]    mode,
  input  logic [DW-1:0] rx_low_a,
  input  logic [DW-1:0] rx_low_b,
  input  logic [DW-1:0] rx_high_a,
  input  logic [DW-1:0] rx_high_b,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_sof,
  output logic          out_eof,
  output logic          frame_accept,
  output logic          frame_reject,
  output logic [1:0]    match_high,
  output logic [1:0]    match_low
);

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  logic       q_push, q_pop, q_full, q_res_en, q_res_keep;
  slot_st_e   q_push_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  rxa_frame_track #(.DW(DW), .BC0(BC0), .BC1(BC1)) u_trk (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_sof   (in_sof),
    .in_eof   (in_eof),
    .mode     (mode),
    .low_a    (rx_low_a),
    .low_b    (rx_low_b),
    .high_a   (rx_high_a),
    .high_b   (rx_high_b),
    .push     (q_push),
    .push_st  (q_push_st),
    .res_en   (q_res_en),
    .res_keep (q_res_keep),
    .accept   (frame_accept),
    .reject   (frame_reject),
    .match_hi (match_high),
    .match_lo (match_low)
  );

  rxa_hold_fifo #(.DW(DW), .DEPTH(DEPTH)) u_hold (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push      (q_push),
    .push_data (in_data),
    .push_sof  (in_sof),
    .push_eof  (in_eof),
    .push_st   (q_push_st),
    .res_en    (q_res_en),
    .res_keep  (q_res_keep),
    .pop       (q_pop),
    .full      (q_full),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_sof   (out_sof),
    .out_eof   (out_eof)
  );

endmodule

// File: rtl/rxa_screen_chk.sv
module rxa_screen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       accept,
  input logic       reject,
  input logic [1:0] match_hi,
  input logic [1:0] match_lo,
  input logic       q_push,
  input logic       q_pop,
  input logic       q_full
);

  p_single_verdict_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && reject));

  p_reject_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> (match_hi == 2'd0 && match_lo == 2'd0));

  p_match_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !reject) |-> ($stable(match_hi) && $stable(match_lo)));

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (q_push && q_full) |-> q_pop);

  p_bcast_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && match_hi == 2'd3) |-> (match_lo != 2'd0));

endmodule

bind rxa_addr_screen rxa_screen_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .accept   (frame_accept),
  .reject   (frame_reject),
  .match_hi (match_high),
  .match_lo (match_low),
  .q_push   (q_push),
  .q_pop    (q_pop),
  .q_full   (q_full)
);

// File: tb/sim_rxa_addr_screen.sv
`timescale 1ns/1ps
module sim_rxa_addr_screen;

  typedef logic [7:0] bq_t[$];
  typedef struct { logic [7:0] d; bit s; bit e; int st; } ent_t;

  localparam logic [7:0] LA = 8'h31, LB = 8'h52, HA = 8'hA4, HB = 8'h07;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic [2:0] mode = 3'b000;
  logic       out_valid, out_sof, out_eof, frame_accept, frame_reject;
  logic [7:0] out_data;
  logic [1:0] match_high, match_low;

  int    checks = 0, errors = 0, cyc = 0;
  string cur_req = "R5";
  bit    done = 0;

  always #10 clk = ~clk;

  rxa_addr_screen u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .mode(mode),
    .rx_low_a(LA), .rx_low_b(LB), .rx_high_a(HA), .rx_high_b(HB),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
    .frame_accept(frame_accept), .frame_reject(frame_reject),
    .match_high(match_high), .match_low(match_low)
  );

  // ---------------- behavioural reference model ----------------
  ent_t       q[$];
  bit         m_active, m_decided, m_keep, m_have;
  int         m_kind;
  logic [7:0] m_first;
  bit         e_ov, e_os, e_oe, e_acc, e_rej;
  logic [7:0] e_od;
  int         e_mh, e_ml;

  function automatic int kind_of(input logic [2:0] m);
    if (m == 3'd0 || m == 3'd2) return 1;
    if (m == 3'd1 || m == 3'd3) return 2;
    if (m == 3'd5) return 3;
    return 0;
  endfunction

  task automatic judge(input int k, input logic [7:0] b1, input logic [7:0] b2,
                       output bit ok, output int h, output int l);
    logic [7:0] lsrc;
    h = 0; l = 0;
    lsrc = (k == 1) ? b1 : b2;
    if (k == 1 || k == 2) begin
      if (lsrc == LA) l = 1; else if (lsrc == LB) l = 2;
    end
    if (k == 2 || k == 3) begin
      if (b1 == HA) h = 1; else if (b1 == HB) h = 2;
      else if (k == 2 && (b1 == 8'hFE || b1 == 8'hFC)) h = 3;
    end
    case (k)
      1: ok = (l != 0);
      2: ok = (h != 0) && (l != 0);
      3: ok = (h != 0);
      default: ok = 1;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_active = 0; m_decided = 0; m_keep = 0; m_have = 0; m_kind = 0; m_first = 0;
      e_ov = 0; e_os = 0; e_oe = 0; e_acc = 0; e_rej = 0; e_od = 0; e_mh = 0; e_ml = 0;
    end else begin
      e_acc = 0; e_rej = 0; e_ov = 0;
      if (q.size() > 0 && q[0].st != 2) begin
        ent_t h;
        h = q.pop_front();
        if (h.st == 1) begin e_ov = 1; e_od = h.d; e_os = h.s; e_oe = h.e; end
      end
      if (in_valid) begin
        if (in_sof) begin
          if (m_active && !m_decided)
            foreach (q[i]) if (q[i].st == 2) q[i].st = 0;
          m_active = 1; m_decided = 0; m_have = 0; m_kind = kind_of(mode);
        end
        if (m_active) begin
          if (m_decided) begin
            if (m_keep) q.push_back('{in_data, in_sof, in_eof, 1});
          end else begin
            int need, got, hh, ll;
            bit ok;
            need = (m_kind == 2) ? 2 : 1;
            got  = m_have ? 2 : 1;
            if (got == need) begin
              judge(m_kind, m_have ? m_first : in_data, in_data, ok, hh, ll);
              foreach (q[i]) if (q[i].st == 2) q[i].st = ok ? 1 : 0;
              m_decided = 1; m_keep = ok; e_acc = ok; e_rej = !ok;
              e_mh = ok ? hh : 0; e_ml = ok ? ll : 0;
              if (ok) q.push_back('{in_data, in_sof, in_eof, 1});
            end else if (in_eof) begin
              foreach (q[i]) if (q[i].st == 2) q[i].st = 0;
              m_decided = 1; m_keep = 0; e_rej = 1; e_mh = 0; e_ml = 0;
            end else begin
              q.push_back('{in_data, in_sof, in_eof, 2});
            end
            if (!m_have) begin m_first = in_data; m_have = 1; end
          end
          if (in_eof) m_active = 0;
        end
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit bad;
      checks++;
      bad = (frame_accept !== e_acc) || (frame_reject !== e_rej) ||
            (match_high !== 2'(e_mh)) || (match_low !== 2'(e_ml)) ||
            (out_valid !== e_ov) ||
            (e_ov && (out_data !== e_od || out_sof !== e_os || out_eof !== e_oe));
      if (bad) begin
        errors++;
        $display("FAIL %s cycle %0d: acc/rej/mh/ml/ov/od/sof/eof actual %b %b %0d %0d %b %h %b %b expected %b %b %0d %0d %b %h %b %b",
                 cur_req, cyc, frame_accept, frame_reject, match_high, match_low,
                 out_valid, out_data, out_sof, out_eof,
                 e_acc, e_rej, e_mh, e_ml, e_ov, e_od, e_os, e_oe);
      end
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0; in_sof = 0; in_eof = 0;
    end
  endtask

  task automatic send(input int md, input int md_late, input bq_t b, input int gap);
    for (int i = 0; i < b.size(); i++) begin
      @(negedge clk);
      mode = (i == 0) ? 3'(md) : 3'(md_late);
      in_valid = 1; in_data = b[i];
      in_sof = (i == 0); in_eof = (i == b.size() - 1);
      if (gap > 0 && i != b.size() - 1) idle(gap);
    end
  endtask

  task automatic stray(input logic [7:0] d);
    @(negedge clk);
    in_valid = 1; in_data = d; in_sof = 0; in_eof = 0;
  endtask

  initial begin
    idle(3);
    @(negedge clk); rst_n = 1;
    cur_req = "R5";
    idle(4);

    cur_req = "R1";
    send(0, 0, '{LA, 8'h11, 8'h22, 8'h33}, 0); idle(4);
    send(2, 2, '{LB, 8'h44}, 0); idle(4);
    cur_req = "R8";
    send(0, 0, '{8'h99, 8'h12, 8'h13}, 0); idle(4);

    cur_req = "R2";
    send(1, 1, '{HA, LA, 8'h01, 8'h02}, 0); idle(4);
    send(3, 3, '{8'hFE, LB, 8'h03}, 1); idle(4);
    send(1, 1, '{8'hFC, LA, 8'h04}, 0); idle(4);
    send(1, 1, '{HB, LB, 8'h05, 8'h06, 8'h07}, 2); idle(4);
    send(1, 1, '{HA, 8'h99, 8'h08}, 0); idle(4);
    send(1, 1, '{LA, LA, 8'h09}, 0); idle(4);

    cur_req = "R3";
    send(5, 5, '{HA, 8'h0A, 8'h0B}, 0); idle(4);
    send(5, 5, '{HB, 8'h0C}, 0); idle(4);
    send(5, 5, '{8'hFE, 8'h0D}, 0); idle(4);

    cur_req = "R4";
    send(4, 4, '{8'h77, 8'h0E}, 0); idle(4);
    send(6, 6, '{8'h00, 8'h0F, 8'h10}, 0); idle(4);
    send(7, 7, '{8'hFF}, 0); idle(4);

    cur_req = "R6";
    send(1, 1, '{HA, LA, 8'h21}, 0);
    send(1, 1, '{HB, LB, 8'h22}, 0);
    send(0, 0, '{8'h55, 8'h23}, 0); idle(6);

    cur_req = "R9";
    send(1, 1, '{HA}, 0); idle(4);
    send(3, 3, '{8'hFE}, 0); idle(4);
    send(0, 0, '{LA}, 0); idle(4);

    cur_req = "R7";
    send(0, 0, '{LA, 8'h61, 8'h62}, 0);
    send(1, 1, '{HA, LB, 8'h63}, 0);
    send(4, 4, '{8'h64, 8'h65}, 0);
    send(0, 0, '{LB}, 0);
    send(0, 0, '{LA}, 0); idle(6);

    cur_req = "R10";
    stray(8'h31); stray(8'h52); idle(3);
    send(1, 0, '{HA, LA, 8'h71}, 0); idle(4);
    send(0, 5, '{LA, 8'h72, 8'h73}, 0); idle(4);
    @(negedge clk); mode = 3'd1; in_valid = 1; in_data = HA; in_sof = 1; in_eof = 0;
    idle(2);
    send(0, 0, '{LB, 8'h74}, 0); idle(6);

    cur_req = "R11";
    for (int g = 0; g < 3; g++) begin
      send(1, 1, '{HB, LA, 8'h80, 8'h81}, g);
      send(0, 0, '{LA, 8'h82}, 0);
      send(1, 1, '{HA, 8'h00, 8'h83}, g);
      send(5, 5, '{HA, 8'h84}, 0);
    end
    idle(10);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule